// File: doc/BRIEF.md
# GPIO Event Detect and Interrupt Unit

This unit watches every input pad of a general-purpose I/O controller and records events on it. Each pad is brought into the core clock domain by a two-flop synchronizer. A previous-sample register behind it lets the unit detect rising and falling edges as well as high and low levels. A second, shorter path detects edges one synchronizer stage earlier and gives a lower-latency trigger. Each pad has six enable bits, one per event kind. Any enabled condition that is present sets the pad's bit in a status register. Software clears that bit by writing 1 to it.

The pads are grouped in 32-bit banks. Each bank raises an interrupt line while any of its status bits is set. The interrupt port always carries four lines: bank 0, the last bank, a copy of the last-bank line, and the OR of all banks. Software reaches the enable and status registers through a 32-bit register port. A write takes effect at the clock edge. A read returns the addressed word in the same cycle.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset every enable register and every status register reads zero, and all four interrupt lines are low.
- R2: With the rising-edge enable set for a pad, a 0-to-1 change on that pad that is applied before clock edge k sets the pad's status bit after edge k+2 and not before.
- R3: With the falling-edge enable set for a pad, a 1-to-0 change applied before edge k sets the status bit after edge k+2.
- R4: With the high-level enable set, a pad held high sets its status bit. A clear write has no effect while the level persists. Once the enable is cleared, a clear write takes effect.
- R5: With the low-level enable set, a pad held low sets its status bit one edge after the enable write. Once the pad has gone high, a clear write takes effect.
- R6: The fast rising and fast falling enables set the status bit after edge k+1 for a change applied before edge k.
- R7: Status is write-1-to-clear. A 1 bit in a write to a status word clears that pad's bit at the write edge. A 0 bit leaves it unchanged. A status bit is cleared only by such a write.
- R8: When a clear write and a new detection of the same pad fall on the same edge, the status bit stays set.
- R9: A pad with all six enables at zero never sets its status bit, whatever it does.
- R10: Several event kinds may be enabled for one pad at once. Each one that occurs sets the status bit.
- R11: irq_o[0] is the OR of the bank-0 status bits. irq_o[1] is the OR of the last bank's status bits. irq_o[2] equals irq_o[1]. irq_o[3] is the OR of all status bits.
- R12: The word map is fixed, with bank b at base + 4*b. The bases are: status 0x40, rising 0x4C, falling 0x58, high 0x64, low 0x70, fast rising 0x7C and fast falling 0x88. Enable bit i of bank b controls pad 32*b+i. Bits of nonexistent pads, and unmapped or unaligned addresses, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_i | input | NUM_PINS | Raw pad levels, asynchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 4 | Interrupts: bank 0, last bank, last-bank copy, all banks |

## Verification
Results arrive at three different latencies. A normal edge or level event becomes visible in status and on the interrupt lines two edges after the edge that first samples the pad change. A fast-path edge becomes visible one edge after it. A register write is visible in read data straight after its edge. The bench applies every stimulus at a falling clock edge and advances in whole cycles. It samples one cycle short of each expected latency to see the bit still clear, and then again at the due cycle to see it set. The collision case is timed so that the clear write shares its edge with the fast-path detection.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int WORD      = 32;
    localparam int KINDS     = 6;
    localparam int SEL_COUNT = KINDS + 1;
    localparam logic [7:0] MAP_BASE = 8'h40;
    localparam int MAP_STRIDE = 12;

    typedef enum logic [2:0] {
        K_RISE  = 3'd0,
        K_FALL  = 3'd1,
        K_HIGH  = 3'd2,
        K_LOW   = 3'd3,
        K_ARISE = 3'd4,
        K_AFALL = 3'd5
    } evt_kind_e;

    typedef struct packed {
        logic       hit;
        logic       is_status;
        logic [2:0] kind;
        logic [1:0] bank;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [7:0] addr, input int nbank);
        reg_dec_t d;
        d = '0;
        for (int g = 0; g < SEL_COUNT; g++) begin
            for (int b = 0; b < nbank; b++) begin
                if (addr == MAP_BASE + 8'(g * MAP_STRIDE + b * 4)) begin
                    d.hit       = 1'b1;
                    d.is_status = (g == 0);
                    d.kind      = (g == 0) ? 3'd0 : 3'(g - 1);
                    d.bank      = 2'(b);
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_evt_sense.sv
module gpio_evt_sense
    import gpio_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pad,
    output logic [KINDS-1:0] cond
);
    logic s1, s2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= pad;
            s2   <= s1;
            prev <= s2;
        end
    end

    always_comb begin
        cond          = '0;
        cond[K_RISE]  = s2 & ~prev;
        cond[K_FALL]  = ~s2 & prev;
        cond[K_HIGH]  = s2;
        cond[K_LOW]   = ~s2;
        cond[K_ARISE] = s1 & ~s2;
        cond[K_AFALL] = ~s1 & s2;
    end

    // R6
    fast_rise_lead_chk: assert property (@(posedge clk) disable iff (rst)
        cond[K_ARISE] |=> cond[K_RISE]);

    // R6
    fast_fall_lead_chk: assert property (@(posedge clk) disable iff (rst)
        cond[K_AFALL] |=> cond[K_FALL]);

endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int NBANK    = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PINS-1:0][KINDS-1:0] cond,
    input  logic                           reg_we,
    input  logic [7:0]                     reg_addr,
    input  logic [WORD-1:0]                reg_wdata,
    output logic [WORD-1:0]                reg_rdata,
    output logic [NUM_PINS-1:0]            sts
);
    reg_dec_t                       dec;
    logic [NUM_PINS-1:0]            hit;
    logic [NUM_PINS-1:0]            clr;
    logic [NUM_PINS-1:0][KINDS-1:0] en_q;

    assign dec = decode_addr(reg_addr, NBANK);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int BK = p / WORD;
        localparam int BT = p % WORD;
        logic [KINDS-1:0] en_r;
        logic             sts_r;
        logic             bank_sel;

        assign bank_sel = reg_we & dec.hit & (dec.bank == 2'(BK));
        assign hit[p]   = |(cond[p] & en_r);
        assign clr[p]   = bank_sel & dec.is_status & reg_wdata[BT];
        assign en_q[p]  = en_r;
        assign sts[p]   = sts_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_r  <= '0;
                sts_r <= 1'b0;
            end else begin
                if (bank_sel && !dec.is_status)
                    en_r[dec.kind] <= reg_wdata[BT];
                // detection has priority over a clear on the same edge
                sts_r <= (sts_r & ~clr[p]) | hit[p];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (dec.hit) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (p / WORD == int'(dec.bank))
                    reg_rdata[p % WORD] = dec.is_status ? sts[p] : en_q[p][dec.kind];
            end
        end
    end

    // R9
    no_unprompted_set_chk: assert property (@(posedge clk) disable iff (rst)
        (sts & ~$past(sts) & ~$past(hit)) == '0);

    // R7
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (sts & $past(clr & ~hit)) == '0);

    // R8
    detect_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (sts & $past(hit)) == $past(hit));

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pad_i,
    input  logic                reg_we,
    input  logic [7:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [3:0]          irq_o
);
    localparam int NBANK = (NUM_PINS + WORD - 1) / WORD;

    logic [NUM_PINS-1:0][KINDS-1:0] cond;
    logic [NUM_PINS-1:0]            sts;
    logic [NBANK-1:0]               bank_irq;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_sense
        gpio_evt_sense u_sense (
            .clk  (clk),
            .rst  (rst),
            .pad  (pad_i[p]),
            .cond (cond[p])
        );
    end

    gpio_evt_regs #(
        .NUM_PINS (NUM_PINS),
        .NBANK    (NBANK)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cond      (cond),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sts       (sts)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int LO = b * WORD;
        localparam int HI = ((b + 1) * WORD < NUM_PINS) ? (b + 1) * WORD - 1 : NUM_PINS - 1;
        assign bank_irq[b] = |sts[HI:LO];
    end

    assign irq_o = {|bank_irq, bank_irq[NBANK-1], bank_irq[NBANK-1], bank_irq[0]};

    // R11
    irq_fall_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o[3]) |-> $past(reg_we));

    // R11
    irq_bank_cover_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o[0] || irq_o[1]) |-> irq_o[3]);

endmodule

// File: tb/gpio_evt_unit_bench.sv
module gpio_evt_unit_bench;
    localparam int NP = 54;
    localparam logic [7:0] A_STS = 8'h40, A_RISE = 8'h4C, A_FALL = 8'h58, A_HIGH = 8'h64,
                           A_LOW = 8'h70, A_ARISE = 8'h7C, A_AFALL = 8'h88;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pad = '0;
    logic          we = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [3:0]    irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gpio_evt_unit #(.NUM_PINS(NP)) u_gpio_evt_unit (
        .clk(clk), .rst(rst), .pad_i(pad), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] ra(input logic [7:0] base, input int b);
        return base + 8'(4 * b);
    endfunction

    function automatic logic [31:0] bank_mask(input int b);
        return (b == 0) ? 32'hFFFF_FFFF : (32'h1 << (NP - 32)) - 32'h1;
    endfunction

    function automatic logic [31:0] irq_exp(input logic [31:0] s0, input logic [31:0] s1);
        return {28'h0, (|s0) | (|s1), |s1, |s1, |s0};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick();
        we = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic set_both(input logic [7:0] base, input logic [31:0] d);
        wr(ra(base, 0), d);
        wr(ra(base, 1), d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every word and the interrupt lines
        for (int g = 0; g < 7; g++)
            for (int b = 0; b < 2; b++)
                rdchk("R1", ra(8'(8'h40 + g * 12), b), 32'h0);
        chk("R1", {28'h0, irq}, 32'h0);

        // R12: enable words keep what is written, nonexistent pads read zero
        for (int g = 1; g < 7; g++)
            for (int b = 0; b < 2; b++) begin
                wr(ra(8'(8'h40 + g * 12), b), 32'hFFFF_FFFF);
                rdchk("R12", ra(8'(8'h40 + g * 12), b), bank_mask(b));
                wr(ra(8'(8'h40 + g * 12), b), 32'h0);
                rdchk("R12", ra(8'(8'h40 + g * 12), b), 32'h0);
            end
        wr(ra(A_HIGH, 0), 32'h5A5A_0001);
        rdchk("R12", 8'h41, 32'h0);
        rdchk("R12", 8'h94, 32'h0);
        rdchk("R12", ra(A_HIGH, 0), 32'h5A5A_0001);
        wr(ra(A_HIGH, 0), 32'h0);
        tick();
        set_both(A_STS, 32'hFFFF_FFFF);
        rdchk("R7", ra(A_STS, 0), 32'h0);
        rdchk("R7", ra(A_STS, 1), 32'h0);

        // R2: rising-edge sweep over every pad
        set_both(A_RISE, 32'hFFFF_FFFF);
        for (int p = 0; p < NP; p++) begin
            pad[p] = 1'b1;
            tick(); tick();
            rdchk("R2", ra(A_STS, p / 32), 32'h0);
            tick();
            rdchk("R2", ra(A_STS, p / 32), 32'h1 << (p % 32));
            chk("R11", {28'h0, irq}, (p < 32) ? irq_exp(32'h1 << p, 0) : irq_exp(0, 32'h1));
            pad[p] = 1'b0;
            wr(ra(A_STS, p / 32), 32'h1 << (p % 32));
            rdchk("R7", ra(A_STS, p / 32), 32'h0);
        end
        set_both(A_RISE, 32'h0);

        // R3: falling-edge sweep over every pad
        pad = '1;
        repeat (4) tick();
        set_both(A_FALL, 32'hFFFF_FFFF);
        for (int p = 0; p < NP; p++) begin
            pad[p] = 1'b0;
            tick(); tick();
            rdchk("R3", ra(A_STS, p / 32), 32'h0);
            tick();
            rdchk("R3", ra(A_STS, p / 32), 32'h1 << (p % 32));
            pad[p] = 1'b1;
            wr(ra(A_STS, p / 32), 32'h1 << (p % 32));
            rdchk("R3", ra(A_STS, p / 32), 32'h0);
        end
        set_both(A_FALL, 32'h0);
        pad = '0;
        repeat (4) tick();

        // R6: fast path, one edge sooner
        set_both(A_ARISE, 32'hFFFF_FFFF);
        set_both(A_AFALL, 32'hFFFF_FFFF);
        foreach (pad[p]) begin
            if (p == 0 || p == 31 || p == 32 || p == 53) begin
                pad[p] = 1'b1;
                tick();
                rdchk("R6", ra(A_STS, p / 32), 32'h0);
                tick();
                rdchk("R6", ra(A_STS, p / 32), 32'h1 << (p % 32));
                wr(ra(A_STS, p / 32), 32'h1 << (p % 32));
                pad[p] = 1'b0;
                tick();
                rdchk("R6", ra(A_STS, p / 32), 32'h0);
                tick();
                rdchk("R6", ra(A_STS, p / 32), 32'h1 << (p % 32));
                wr(ra(A_STS, p / 32), 32'h1 << (p % 32));
            end
        end
        set_both(A_ARISE, 32'h0);
        set_both(A_AFALL, 32'h0);

        // R8: clear write shares its edge with a fresh fast detection
        wr(ra(A_ARISE, 0), 32'h400);
        pad[10] = 1'b1;
        tick(); tick();
        pad[10] = 1'b0;
        repeat (3) tick();
        rdchk("R8", ra(A_STS, 0), 32'h400);
        pad[10] = 1'b1;
        tick();
        wr(ra(A_STS, 0), 32'h400);
        rdchk("R8", ra(A_STS, 0), 32'h400);
        wr(ra(A_STS, 0), 32'h400);
        rdchk("R7", ra(A_STS, 0), 32'h0);
        wr(ra(A_ARISE, 0), 32'h0);
        pad[10] = 1'b0;
        repeat (3) tick();

        // R4: high level resists clearing until masked
        wr(ra(A_HIGH, 0), 32'h20);
        pad[5] = 1'b1;
        repeat (3) tick();
        rdchk("R4", ra(A_STS, 0), 32'h20);
        wr(ra(A_STS, 0), 32'h20);
        rdchk("R4", ra(A_STS, 0), 32'h20);
        wr(ra(A_HIGH, 0), 32'h0);
        wr(ra(A_STS, 0), 32'h20);
        rdchk("R4", ra(A_STS, 0), 32'h0);
        pad[5] = 1'b0;
        repeat (3) tick();

        // R5: low level on pad 40 (bank 1, bit 8)
        wr(ra(A_LOW, 1), 32'h100);
        tick();
        rdchk("R5", ra(A_STS, 1), 32'h100);
        chk("R11", {28'h0, irq}, irq_exp(0, 32'h100));
        pad[40] = 1'b1;
        repeat (3) tick();
        wr(ra(A_STS, 1), 32'h100);
        rdchk("R5", ra(A_STS, 1), 32'h0);
        chk("R11", {28'h0, irq}, 32'h0);
        wr(ra(A_LOW, 1), 32'h0);
        pad[40] = 1'b0;
        repeat (3) tick();

        // R9: activity with nothing enabled
        pad = {27{2'b10}};
        repeat (4) tick();
        pad = '0;
        repeat (4) tick();
        rdchk("R9", ra(A_STS, 0), 32'h0);
        rdchk("R9", ra(A_STS, 1), 32'h0);
        chk("R9", {28'h0, irq}, 32'h0);

        // R10: rising and falling together on pad 3
        wr(ra(A_RISE, 0), 32'h8);
        wr(ra(A_FALL, 0), 32'h8);
        pad[3] = 1'b1;
        repeat (3) tick();
        rdchk("R10", ra(A_STS, 0), 32'h8);
        wr(ra(A_STS, 0), 32'h8);
        pad[3] = 1'b0;
        repeat (3) tick();
        rdchk("R10", ra(A_STS, 0), 32'h8);
        wr(ra(A_STS, 0), 32'h8);
        rdchk("R10", ra(A_STS, 0), 32'h0);
        wr(ra(A_RISE, 0), 32'h0);
        wr(ra(A_FALL, 0), 32'h0);

        // R7: zero bits leave status alone
        wr(ra(A_ARISE, 0), 32'h6);
        pad[1] = 1'b1;
        pad[2] = 1'b1;
        tick(); tick();
        rdchk("R7", ra(A_STS, 0), 32'h6);
        wr(ra(A_STS, 0), 32'h4);
        rdchk("R7", ra(A_STS, 0), 32'h2);
        wr(ra(A_STS, 0), 32'h0);
        rdchk("R7", ra(A_STS, 0), 32'h2);
        wr(ra(A_STS, 0), 32'h2);
        rdchk("R7", ra(A_STS, 0), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule